// File: doc/BRIEF.md
# Shared Single-Port Memory Controller with Priority Arbitration and Address Generators

This block lets up to four processor ports share one single-ported word memory. Each port asserts a request together with a direction, an address mode and, for writes, a data word. An arbiter picks at most one requesting port per clock cycle. The pick uses each port's priority level first and a rotating order among ports at the same level second. A requesting port keeps its request high until it sees its grant. The granted port's access is applied to the memory on the clock edge that ends the grant cycle.

Each port has its own address generator. A port can supply every address directly. It can also let the generator walk a stride through the whole array, or cycle through a window set by a base and a length. This lets a processor stream data without sending an address with each request. The storage holds 2**ADDR_W words of 16 bits. ADDR_W = 13 gives the 16 KB configuration. The default is smaller so that elaboration stays light.

Top module: `shmem_ctrl`

## Requirements
- R1: While reset is low, and on the first cycle after it, every grant and read-valid output is 0 and every port's read-data bus is 0.
- R2: At most one grant bit is high in any cycle, and only for a port whose request is high.
- R3: Each priority field is 2 bits and a larger value means more urgent. When requests contend, the grant goes to a requester with the largest priority value.
- R4: Among requesters at the same highest priority, the grant goes to the first one found when counting upward, with wrap-around, from the port granted last. After reset the last-granted port is taken as port N-1, so port 0 is first in line.
- R5: A granted request with write enable 1 stores its data word at the generated address on the edge that ends the grant cycle. It raises no read-valid.
- R6: A granted request with write enable 0 raises that port's read-valid for the following cycle. In that cycle the port's read-data bus carries the addressed word. At other times a port's read-data bus keeps the last word returned to that port.
- R7: Mode 2'b00 (direct), and the unused code 2'b11 as well, takes the address from the port's address input.
- R8: Mode 2'b01 (stride) uses the port's pointer as the address. Each grant in this mode advances the pointer by the stride, modulo the array depth. The pointer does not change on any other cycle.
- R9: Mode 2'b10 (circular) uses base plus offset as the address. Each grant in this mode advances the offset by the stride and subtracts the length when the sum reaches the length. The stride must not exceed the length.
- R10: A configuration load on a port stores base, stride and length, sets the pointer to the base and clears the offset. When a load and a grant fall in the same cycle, the load sets the next state and the access uses the address from before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all ports |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | N | Request per port, held until granted |
| we_i | input | N | Write enable per port |
| mode_i | input | 2*N | Address mode per port |
| addr_i | input | ADDR_W*N | Direct address per port |
| wdata_i | input | 16*N | Write data per port |
| prio_i | input | 2*N | Priority level per port |
| cfg_ld_i | input | N | Load generator configuration per port |
| cfg_base_i | input | ADDR_W*N | Generator base address per port |
| cfg_stride_i | input | ADDR_W*N | Generator step per port |
| cfg_len_i | input | ADDR_W*N | Circular window length per port |
| gnt_o | output | N | Grant per port, combinational in the request cycle |
| rvalid_o | output | N | Read data valid per port |
| rdata_o | output | 16*N | Read data per port |

## Verification
Two events can fall in the same cycle: a grant that advances a port's stride pointer, and a configuration load on that port. The bench raises a stride-mode write request and a configuration load on the same port at the same clock phase. It then reads back directly both the old pointer's location and the new base location. The write must land at the old address, and the next stride access must use the freshly loaded base. Contention is provoked the same way. Several ports raise requests at the same edge with unequal priorities or with equal ones, and the grant vector is compared cycle by cycle with the order that the priority and rotation rules predict.

// File: rtl/shmem_pkg.sv
// Package: shared types for the shared memory controller.
// Assumes: address mode codes are fixed; port count and widths come from parameters.
package shmem_pkg;

    // Address mode codes carried on each port's mode field
    typedef enum logic [1:0] {
        AM_DIRECT = 2'b00,
        AM_STRIDE = 2'b01,
        AM_CIRC   = 2'b10,
        AM_RSVD   = 2'b11
    } addr_mode_e;

    localparam int unsigned PRIO_W = 2;
    localparam int unsigned MODE_W = 2;

endpackage

// File: rtl/shmem_arbiter.sv
// Module: picks one requesting port per cycle. The highest priority value wins.
// Ties are broken by rotating from the port granted last.
// Assumes: requests are held until granted; the grant is combinational in the request cycle.
module shmem_arbiter
    import shmem_pkg::*;
#(
    parameter int unsigned N_PORTS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_PORTS-1:0]          req_i,
    input  logic [PRIO_W*N_PORTS-1:0]   prio_i,
    output logic [N_PORTS-1:0]          gnt_o,
    output logic [$clog2(N_PORTS)-1:0]  gnt_idx_o,
    output logic                        gnt_any_o
);
    localparam int unsigned IW = $clog2(N_PORTS);

    logic [IW-1:0]     rr_q;
    logic [PRIO_W-1:0] top_prio;
    logic [IW-1:0]     win;
    logic              found;
    int unsigned       cand;

    // Find the highest requested priority, then the first matching port after rr_q
    always_comb begin
        top_prio = '0;
        for (int i = 0; i < N_PORTS; i++) begin
            if (req_i[i] && (prio_i[i*PRIO_W +: PRIO_W] > top_prio)) begin
                top_prio = prio_i[i*PRIO_W +: PRIO_W];
            end
        end
        win   = '0;
        found = 1'b0;
        cand  = 0;
        for (int k = 1; k <= N_PORTS; k++) begin
            cand = (int'(rr_q) + k) % N_PORTS;
            if (!found && req_i[cand] && (prio_i[cand*PRIO_W +: PRIO_W] == top_prio)) begin
                found = 1'b1;
                win   = IW'(cand);
            end
        end
    end

    // Build the one-hot grant; nothing is granted in reset
    always_comb begin
        gnt_o     = '0;
        gnt_any_o = found && rst_n;
        gnt_idx_o = win;
        if (gnt_any_o) begin
            gnt_o[win] = 1'b1;
        end
    end

    // Remember the last granted port for rotation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= IW'(N_PORTS - 1);
        end else if (gnt_any_o) begin
            rr_q <= win;
        end
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt_o)); // R2

    for (genvar gi = 0; gi < N_PORTS; gi++) begin : g_chk
        AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n) gnt_o[gi] |-> req_i[gi]); // R2
        for (genvar gj = 0; gj < N_PORTS; gj++) begin : g_pair
            AST_PRIO_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
                (gnt_o[gi] && req_i[gj]) |-> (prio_i[gj*PRIO_W +: PRIO_W] <= prio_i[gi*PRIO_W +: PRIO_W])); // R3
        end
    end

endmodule

// File: rtl/shmem_addr_gen.sv
// Module: per-port address generator with direct, stride and circular window modes.
// Assumes: adv_i is this port's grant; in circular mode the stride does not exceed the length.
module shmem_addr_gen
    import shmem_pkg::*;
#(
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              adv_i,
    input  logic              cfg_ld_i,
    input  logic [ADDR_W-1:0] cfg_base_i,
    input  logic [ADDR_W-1:0] cfg_stride_i,
    input  logic [ADDR_W-1:0] cfg_len_i,
    output logic [ADDR_W-1:0] addr_o
);
    addr_mode_e        mode;
    logic [ADDR_W-1:0] base_q, stride_q, len_q, ptr_q, off_q;
    logic [ADDR_W:0]   off_sum;
    logic [ADDR_W-1:0] off_nxt;

    assign mode = addr_mode_e'(mode_i);

    // Next window offset: step, then fold back by the length
    always_comb begin
        off_sum = {1'b0, off_q} + {1'b0, stride_q};
        if (off_sum >= {1'b0, len_q}) begin
            off_nxt = ADDR_W'(off_sum - {1'b0, len_q});
        end else begin
            off_nxt = off_sum[ADDR_W-1:0];
        end
    end

    // Choose the address presented for this port's access
    always_comb begin
        case (mode)
            AM_STRIDE: addr_o = ptr_q;
            AM_CIRC:   addr_o = base_q + off_q;
            default:   addr_o = addr_i;
        endcase
    end

    // Load the configuration, or advance the pointer of the active mode on a grant
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            stride_q <= '0;
            len_q    <= '0;
            ptr_q    <= '0;
            off_q    <= '0;
        end else if (cfg_ld_i) begin
            base_q   <= cfg_base_i;
            stride_q <= cfg_stride_i;
            len_q    <= cfg_len_i;
            ptr_q    <= cfg_base_i;
            off_q    <= '0;
        end else if (adv_i) begin
            if (mode == AM_STRIDE) ptr_q <= ptr_q + stride_q;
            if (mode == AM_CIRC)   off_q <= off_nxt;
        end
    end

    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ld_i |=> (ptr_q == $past(cfg_base_i) && off_q == '0)); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !cfg_ld_i) |=> ($stable(ptr_q) && $stable(off_q))); // R8

endmodule

// File: rtl/shmem_array.sv
// Module: behavioural single-ported word memory with one access per cycle.
// Assumes: a read returns its word one cycle later on a registered output; contents are not reset.
module shmem_array #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              en_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Perform the single write or read of this cycle
    always_ff @(posedge clk) begin
        if (en_i) begin
            if (we_i) begin
                mem[addr_i] <= wdata_i;
            end else begin
                rdata_o <= mem[addr_i];
            end
        end
    end

endmodule

// File: rtl/shmem_ctrl.sv
// Module: top of the shared memory controller. It arbitrates the ports, muxes the
// winner's generated address onto the memory and routes read data back to that port.
// Assumes: a single clock for all ports; the winner's access happens on the edge ending its grant cycle.
module shmem_ctrl
    import shmem_pkg::*;
#(
    parameter int unsigned N_PORTS = 4,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned ADDR_W  = 11
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_PORTS-1:0]          req_i,
    input  logic [N_PORTS-1:0]          we_i,
    input  logic [MODE_W*N_PORTS-1:0]   mode_i,
    input  logic [ADDR_W*N_PORTS-1:0]   addr_i,
    input  logic [DATA_W*N_PORTS-1:0]   wdata_i,
    input  logic [PRIO_W*N_PORTS-1:0]   prio_i,
    input  logic [N_PORTS-1:0]          cfg_ld_i,
    input  logic [ADDR_W*N_PORTS-1:0]   cfg_base_i,
    input  logic [ADDR_W*N_PORTS-1:0]   cfg_stride_i,
    input  logic [ADDR_W*N_PORTS-1:0]   cfg_len_i,
    output logic [N_PORTS-1:0]          gnt_o,
    output logic [N_PORTS-1:0]          rvalid_o,
    output logic [DATA_W*N_PORTS-1:0]   rdata_o
);
    localparam int unsigned IW = $clog2(N_PORTS);

    logic [IW-1:0]     gnt_idx;
    logic              gnt_any;
    logic [ADDR_W-1:0] gen_addr [N_PORTS];
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;
    logic              rd_valid_q;
    logic [IW-1:0]     rd_idx_q;
    logic [DATA_W-1:0] held_q [N_PORTS];

    shmem_arbiter #(.N_PORTS(N_PORTS)) arb_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_i),
        .prio_i   (prio_i),
        .gnt_o    (gnt_o),
        .gnt_idx_o(gnt_idx),
        .gnt_any_o(gnt_any)
    );

    for (genvar gp = 0; gp < N_PORTS; gp++) begin : g_port
        shmem_addr_gen #(.ADDR_W(ADDR_W)) agen_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .mode_i      (mode_i[gp*MODE_W +: MODE_W]),
            .addr_i      (addr_i[gp*ADDR_W +: ADDR_W]),
            .adv_i       (gnt_o[gp]),
            .cfg_ld_i    (cfg_ld_i[gp]),
            .cfg_base_i  (cfg_base_i[gp*ADDR_W +: ADDR_W]),
            .cfg_stride_i(cfg_stride_i[gp*ADDR_W +: ADDR_W]),
            .cfg_len_i   (cfg_len_i[gp*ADDR_W +: ADDR_W]),
            .addr_o      (gen_addr[gp])
        );

        // Read valid for this port in the cycle after its read grant
        assign rvalid_o[gp] = rd_valid_q && (rd_idx_q == IW'(gp));
        // Fresh word while valid, otherwise the last word returned to this port
        assign rdata_o[gp*DATA_W +: DATA_W] = rvalid_o[gp] ? mem_rdata : held_q[gp];

        AST_READ_RESP: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt_o[gp] && !we_i[gp]) |=> rvalid_o[gp]); // R6
        AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt_o[gp] && we_i[gp]) |=> !rvalid_o[gp]); // R5
    end

    // Steer the winning port's access onto the memory
    always_comb begin
        mem_addr  = gen_addr[gnt_idx];
        mem_we    = we_i[gnt_idx];
        mem_wdata = wdata_i[gnt_idx*DATA_W +: DATA_W];
    end

    shmem_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) mem_i (
        .clk    (clk),
        .en_i   (gnt_any),
        .we_i   (mem_we),
        .addr_i (mem_addr),
        .wdata_i(mem_wdata),
        .rdata_o(mem_rdata)
    );

    // Track which port owns the read returning next cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            rd_idx_q   <= '0;
        end else begin
            rd_valid_q <= gnt_any && !mem_we;
            rd_idx_q   <= gnt_idx;
        end
    end

    // Keep each port's last returned word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_PORTS; i++) held_q[i] <= '0;
        end else if (rd_valid_q) begin
            held_q[rd_idx_q] <= mem_rdata;
        end
    end

    AST_ONE_RVALID: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(rvalid_o)); // R6

endmodule

// File: tb/shmem_ctrl_tb.sv
`timescale 1ns/1ps
module shmem_ctrl_tb_top;
    localparam int NP = 4;
    localparam int DW = 16;
    localparam int AW = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0]    req = '0, we = '0, cfg_ld = '0;
    logic [2*NP-1:0]  mode = '0, prio = '0;
    logic [AW*NP-1:0] addr = '0, cfg_base = '0, cfg_stride = '0, cfg_len = '0;
    logic [DW*NP-1:0] wdata = '0;
    logic [NP-1:0]    gnt, rvalid;
    logic [DW*NP-1:0] rdata;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    shmem_ctrl #(.N_PORTS(NP), .DATA_W(DW), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .mode_i(mode),
        .addr_i(addr), .wdata_i(wdata), .prio_i(prio), .cfg_ld_i(cfg_ld),
        .cfg_base_i(cfg_base), .cfg_stride_i(cfg_stride), .cfg_len_i(cfg_len),
        .gnt_o(gnt), .rvalid_o(rvalid), .rdata_o(rdata)
    );

    // Row: port(2) we(1) mode(2) addr(11) wdata(16) expected read(16)
    localparam logic [47:0] VEC [16] = '{
        {2'd0, 1'b1, 2'b00, 11'd10,   16'hA001, 16'h0000}, // R7 direct write
        {2'd0, 1'b0, 2'b00, 11'd10,   16'h0000, 16'hA001}, // R6 R7 read back
        {2'd1, 1'b1, 2'b00, 11'd11,   16'hB002, 16'h0000}, // R5
        {2'd1, 1'b0, 2'b00, 11'd11,   16'h0000, 16'hB002}, // R6
        {2'd0, 1'b1, 2'b01, 11'd0,    16'h1111, 16'h0000}, // R8 stride -> 200
        {2'd0, 1'b1, 2'b01, 11'd0,    16'h2222, 16'h0000}, // R8 stride -> 203
        {2'd1, 1'b0, 2'b00, 11'd200,  16'h0000, 16'h1111}, // R8
        {2'd1, 1'b0, 2'b00, 11'd203,  16'h0000, 16'h2222}, // R8
        {2'd1, 1'b1, 2'b10, 11'd0,    16'h3330, 16'h0000}, // R9 -> 300
        {2'd1, 1'b1, 2'b10, 11'd0,    16'h3331, 16'h0000}, // R9 -> 302
        {2'd1, 1'b1, 2'b10, 11'd0,    16'h3332, 16'h0000}, // R9 -> 304
        {2'd1, 1'b1, 2'b10, 11'd0,    16'h3333, 16'h0000}, // R9 wrap -> 301
        {2'd0, 1'b0, 2'b00, 11'd301,  16'h0000, 16'h3333}, // R9
        {2'd0, 1'b0, 2'b00, 11'd300,  16'h0000, 16'h3330}, // R9
        {2'd0, 1'b0, 2'b00, 11'd304,  16'h0000, 16'h3332}, // R9
        {2'd0, 1'b0, 2'b11, 11'd10,   16'h0000, 16'hA001}  // R7 unused code acts direct
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input int p, input logic w, input logic [1:0] m, input logic [AW-1:0] a, input logic [DW-1:0] d);
        we[p] = w;
        mode[p*2 +: 2] = m;
        addr[p*AW +: AW] = a;
        wdata[p*DW +: DW] = d;
        req[p] = 1'b1;
    endtask

    task automatic run_op(input int p, input logic w, input logic [1:0] m, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input logic [DW-1:0] exp, input string tag);
        @(negedge clk);
        drive(p, w, m, a, d);
        #1;
        while (!gnt[p]) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        req[p] = 1'b0;
        #1;
        if (w) begin
            check(rvalid == '0, {tag, " write raises no valid (R5)"}, rvalid, 0);
        end else begin
            check(rvalid == (NP'(1) << p), {tag, " read valid (R6)"}, rvalid, NP'(1) << p);
            check(rdata[p*DW +: DW] == exp, {tag, " read data"}, rdata[p*DW +: DW], exp);
        end
    endtask

    task automatic configure(input int p, input logic [AW-1:0] b, input logic [AW-1:0] s, input logic [AW-1:0] l);
        @(negedge clk);
        cfg_base[p*AW +: AW] = b;
        cfg_stride[p*AW +: AW] = s;
        cfg_len[p*AW +: AW] = l;
        cfg_ld[p] = 1'b1;
        @(negedge clk);
        cfg_ld[p] = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req = '0;
        cfg_ld = '0;
        repeat (3) @(negedge clk);
        #1;
        check(gnt == '0 && rvalid == '0, "R1 outputs quiet in reset", {gnt, rvalid}, 0);
        rst_n = 1'b1;
        #1;
        check(gnt == '0 && rvalid == '0, "R1 grant/valid after reset", {gnt, rvalid}, 0);
        check(rdata == '0, "R1 read data after reset", rdata, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired, actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        do_reset();

        configure(0, 11'd200, 11'd3, 11'd0);
        configure(1, 11'd300, 11'd2, 11'd5);
        for (int r = 0; r < 16; r++) begin
            run_op(int'(VEC[r][47:46]), VEC[r][45], VEC[r][44:43], VEC[r][42:32],
                   VEC[r][31:16], VEC[r][15:0], $sformatf("vector row %0d", r));
        end

        // R3: port 0 at level 1 against port 2 at level 3
        @(negedge clk);
        prio = '0;
        prio[0 +: 2] = 2'd1;
        prio[4 +: 2] = 2'd3;
        drive(0, 1'b0, 2'b00, 11'd10, 16'h0);
        drive(2, 1'b0, 2'b00, 11'd11, 16'h0);
        #1;
        check(gnt == 4'b0100, "R3 higher level wins", gnt, 4'b0100);
        @(negedge clk);
        req[2] = 1'b0;
        #1;
        check(rvalid == 4'b0100 && rdata[2*DW +: DW] == 16'hB002, "R6 port 2 data", rdata[2*DW +: DW], 16'hB002);
        check(gnt == 4'b0001, "R2 held request granted next", gnt, 4'b0001);
        @(negedge clk);
        req[0] = 1'b0;
        #1;
        check(rvalid == 4'b0001 && rdata[DW-1:0] == 16'hA001, "R6 port 0 data", rdata[DW-1:0], 16'hA001);
        check(rdata[2*DW +: DW] == 16'hB002, "R6 port 2 holds last word", rdata[2*DW +: DW], 16'hB002);
        prio = '0;

        // R10: load and stride grant in the same cycle
        configure(0, 11'd500, 11'd4, 11'd0);
        run_op(0, 1'b1, 2'b01, 11'd0, 16'h4444, 16'h0, "R10 stride write at 500");
        @(negedge clk);
        drive(0, 1'b1, 2'b01, 11'd0, 16'h5A5A);
        cfg_base[0 +: AW] = 11'd600;
        cfg_stride[0 +: AW] = 11'd1;
        cfg_ld[0] = 1'b1;
        #1;
        check(gnt == 4'b0001, "R10 grant during load", gnt, 4'b0001);
        @(negedge clk);
        req[0] = 1'b0;
        cfg_ld[0] = 1'b0;
        run_op(0, 1'b1, 2'b01, 11'd0, 16'h6666, 16'h0, "R10 first access after load");
        run_op(1, 1'b0, 2'b00, 11'd504, 16'h0, 16'h5A5A, "R10 same-cycle write used old address");
        run_op(1, 1'b0, 2'b00, 11'd600, 16'h0, 16'h6666, "R10 pointer restarted at base");
        run_op(1, 1'b0, 2'b00, 11'd500, 16'h0, 16'h4444, "R8 earlier stride word");

        // R8: stride pointer wraps modulo depth
        configure(0, 11'd2046, 11'd3, 11'd0);
        run_op(0, 1'b1, 2'b01, 11'd0, 16'h7777, 16'h0, "R8 write at 2046");
        run_op(0, 1'b1, 2'b01, 11'd0, 16'h8888, 16'h0, "R8 write after wrap");
        run_op(1, 1'b0, 2'b00, 11'd1, 16'h0, 16'h8888, "R8 wrapped to 1");
        run_op(1, 1'b0, 2'b00, 11'd2046, 16'h0, 16'h7777, "R8 top word");

        // R4: equal levels rotate from port 0 after reset
        do_reset();
        @(negedge clk);
        prio = {2'd2, 2'd0, 2'd2, 2'd2};
        drive(0, 1'b0, 2'b00, 11'd10, 16'h0);
        drive(1, 1'b0, 2'b00, 11'd10, 16'h0);
        drive(3, 1'b0, 2'b00, 11'd10, 16'h0);
        #1;
        check(gnt == 4'b0001, "R4 first grant port 0", gnt, 4'b0001);
        @(negedge clk); #1;
        check(gnt == 4'b0010, "R4 then port 1", gnt, 4'b0010);
        check(rvalid == 4'b0001, "R6 valid for port 0", rvalid, 4'b0001);
        @(negedge clk); #1;
        check(gnt == 4'b1000, "R4 then port 3", gnt, 4'b1000);
        @(negedge clk); #1;
        check(gnt == 4'b0001, "R4 wrap to port 0", gnt, 4'b0001);
        check(rvalid == 4'b1000 && rdata[3*DW +: DW] == 16'hA001, "R6 port 3 data", rdata[3*DW +: DW], 16'hA001);
        @(negedge clk);
        req = '0;
        #1;
        check(gnt == '0, "R2 no grant without request", gnt, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule